// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block performs one access at a time to an external asynchronous memory or peripheral. A request carries an address, write data, two byte enables and a read/write flag. The block runs the access as three timed phases: setup, pulse and hold. During those phases it drives the chip select, the read strobe, the write strobes and the byte-lane strobes. It ends with a one-cycle done pulse, and for a read it returns the captured data.

Configuration inputs set the following, and are held steady while an access runs:
- the bus width, 8-bit or 16-bit;
- the lane scheme on a 16-bit bus: one write strobe plus two lane-select strobes, or one write strobe per lane;
- which signal times a write: the write strobe or the chip select;
- how the active-low wait input stretches the pulse phase.

There are three groups of phase counts: reads, strobe-timed writes and select-timed writes. The group is picked when the request is accepted.

Top module: `smc_cycle_seq`

## Requirements
- R1: After reset, and whenever no access is running, every strobe output (chip select, read, write, both per-lane write strobes, both lane selects) is high, `ready` is 1 and `done` is 0.
- R2: Accepting a request (`req` high while `ready`) starts an access. Setup lasts S cycles (0 allowed), pulse lasts P cycles with P=0 treated as 1, and hold lasts H cycles (0 allowed). `done` is high for exactly one cycle, S+P+H clock edges after the accepting edge. The controlling strobe is low for exactly the pulse cycles.
- R3: With wait mode 0 (ignored), the wait input has no effect on any access timing.
- R4: With wait mode 2 (freeze), a low wait during the pulse halts the pulse count. Counting resumes where it stopped once wait is seen high again.
- R5: With wait mode 3 (ready), the pulse cannot end while wait is seen low on its final count. It ends on the first cycle that wait is seen high.
- R6: The wait input is never considered during setup or hold. A low wait in those phases leaves the timing unchanged.
- R7: With wait mode 2 or 3, a programmed hold of 0 is lengthened to 1 cycle.
- R8: The wait input reaches the phase logic through a two-flop synchronizer. A change at the pin acts two cycles later.
- R9: A read captures the data bus on the clock edge that ends the pulse. On an 8-bit bus the upper byte of `rdata` reads 0.
- R10: Bus width 1 (16-bit) with lane mode 0 (lane select): the write strobe times the data, and lane select i is low, for the whole access, when byte enable i is set. Reads use chip select and the read strobe.
- R11: Bus width 1 with lane mode 1 (per-lane write): the per-lane write strobe i pulses when byte enable i is set. The single write strobe and both lane selects stay high. Reads use only chip select and the read strobe.
- R12: Write-timing bit 1: the chip select covers the whole write, the write strobe pulses, and the write group of counts is used. Write-timing bit 0: the write strobe covers the whole write, the chip select pulses, and the select group of counts is used. Reads always use the read group.
- R13: Wait mode 1 behaves as mode 0. Bus width values 2 and 3 behave as 8-bit.
- R14: A request made while an access is running is ignored. No second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit i for lane i |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | 16 | Captured read data |
| cfg_wait_mode | input | 2 | 0 ignore, 1 treated as 0, 2 freeze, 3 ready |
| cfg_bus_width | input | 2 | 1 = 16-bit, any other value = 8-bit |
| cfg_lane_mode | input | 1 | 16-bit only: 0 lane select, 1 per-lane write strobes |
| cfg_wr_by_strobe | input | 1 | 1 write strobe times writes, 0 chip select times writes |
| rd_setup | input | TW | Read setup count |
| rd_pulse | input | TW | Read pulse count |
| rd_hold | input | TW | Read hold count |
| wr_setup | input | TW | Strobe-timed write setup count |
| wr_pulse | input | TW | Strobe-timed write pulse count |
| wr_hold | input | TW | Strobe-timed write hold count |
| cs_setup | input | TW | Select-timed write setup count |
| cs_pulse | input | TW | Select-timed write pulse count |
| cs_hold | input | TW | Select-timed write hold count |
| mem_addr | output | AW | Address held for the access |
| mem_dout | output | 16 | Write data to the bus |
| mem_dout_en | output | 1 | Bus drive enable during a write |
| mem_din | input | 16 | Data from the bus |
| mem_wait_n | input | 1 | Active-low wait from the device |
| mem_cs_n | output | 1 | Chip select |
| mem_rd_n | output | 1 | Read strobe |
| mem_we_n | output | 1 | Write strobe |
| mem_wrb_n | output | 2 | Per-lane write strobes |
| mem_bs_n | output | 2 | Lane selects |

## Verification
Accesses are tried with random phase counts, every configuration value including the reserved ones, and random wait releases. Each run is compared with a closed-form length: S+P+H, plus the frozen cycles in freeze mode, or the pulse end pushed to the release in ready mode. This separates a counter that stalls from one that only stretches its last count. Directed cases cover the following:
- a wait that is low only before the pulse, which must change nothing;
- a wait that is low only in hold;
- zero counts and maximum counts;
- a reserved mode holding wait low;
- a request made during a busy access.

Each access checks the strobe pattern cycle by cycle. This tells apart the lane-select scheme, the per-lane write scheme, and strobe-timed against select-timed writes. The data bus is changed right after the pulse, so a late capture of read data is exposed.

// File: rtl/smc_pkg.sv
// Shared types for the static memory bus cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package smc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_DONE  = 3'd4
    } phase_t;

    localparam logic [1:0] WAIT_OFF    = 2'd0;
    localparam logic [1:0] WAIT_FREEZE = 2'd2;
    localparam logic [1:0] WAIT_READY  = 2'd3;
    localparam logic [1:0] BUS_16      = 2'd1;
endpackage

// File: rtl/smc_wait_sync.sv
// Multi-flop synchronizer for the asynchronous active-low wait input.
// Assumes: STAGES >= 2; resets to the inactive (high) level.
module smc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/smc_phase_ctl.sv
// Phase sequencer: counts setup, pulse and hold. The pulse count is
// stalled by a frozen wait or stretched by a ready wait.
// Assumes: counts and wait flags are stable while an access runs;
// pulse_len is already at least 1.
module smc_phase_ctl import smc_pkg::*; #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] pulse_len,
    input  logic [TW-1:0] hold_len,
    input  logic          wait_freeze,
    input  logic          wait_ready,
    input  logic          wait_low,
    output phase_t        phase,
    output logic          pulse_end
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] p_len_q;
    logic [TW-1:0] h_len_q;
    logic          stall;

    assign stall     = wait_low && (wait_freeze || wait_ready);
    assign pulse_end = (phase == PH_PULSE) && (cnt == '0) && !stall;

    // Advance the phase and its down-counter once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            p_len_q <= '0;
            h_len_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    p_len_q <= pulse_len;
                    h_len_q <= hold_len;
                    if (setup_len != '0) begin
                        phase <= PH_SETUP;
                        cnt   <= setup_len - TW'(1);
                    end else begin
                        phase <= PH_PULSE;
                        cnt   <= pulse_len - TW'(1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= p_len_q - TW'(1);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_PULSE: begin
                    if (wait_freeze && wait_low) begin
                        cnt <= cnt;
                    end else if (cnt == '0) begin
                        if (wait_ready && wait_low) begin
                            phase <= PH_PULSE;
                        end else if (h_len_q != '0) begin
                            phase <= PH_HOLD;
                            cnt   <= h_len_q - TW'(1);
                        end else begin
                            phase <= PH_DONE;
                        end
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_DONE;
                    else           cnt   <= cnt - TW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE));
    p_freeze_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wait_freeze && wait_low) |=> (phase == PH_PULSE && $stable(cnt)));
    p_ready_extends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wait_ready && wait_low && cnt == '0) |=> (phase == PH_PULSE));
    p_setup_ignores_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && cnt != '0) |=> (phase == PH_SETUP && cnt == $past(cnt) - TW'(1)));
    p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && (wait_freeze || wait_ready)) |=> (phase != PH_DONE));
endmodule

// File: rtl/smc_strobe_map.sv
// Decodes the phase and the lane configuration into the active-low bus strobes.
// Assumes: configuration is stable during an access; LANES is 2.
module smc_strobe_map import smc_pkg::*; #(
    parameter int LANES = 2
) (
    input  phase_t           phase,
    input  logic             op_wr,
    input  logic             wr_by_strobe,
    input  logic             bus16,
    input  logic             lane_mode,
    input  logic [LANES-1:0] be,
    output logic             cs_n,
    output logic             rd_n,
    output logic             we_n,
    output logic [LANES-1:0] wrb_n,
    output logic [LANES-1:0] bs_n
);
    logic active, pulse, wr_win, cs_win, lane_sel, lane_wr;

    // Work out the low windows of the chip select and the write strobes.
    always_comb begin
        active   = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
        pulse    = (phase == PH_PULSE);
        lane_sel = bus16 && !lane_mode;
        lane_wr  = bus16 && lane_mode;
        wr_win   = op_wr && (wr_by_strobe ? pulse : active);
        cs_win   = (op_wr && !wr_by_strobe) ? pulse : active;
    end

    assign cs_n = !cs_win;
    assign rd_n = !(pulse && !op_wr);
    assign we_n = !(wr_win && !lane_wr);

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            assign wrb_n[i] = !(wr_win && lane_wr && be[i]);
            assign bs_n[i]  = !(active && lane_sel && be[i]);
        end
    endgenerate
endmodule

// File: rtl/smc_cycle_seq.sv
// Top level: accepts one request, selects its group of phase counts,
// runs the access and returns read data with a done pulse.
// Assumes: cfg_* and timing inputs are stable from the accepting edge to done.
module smc_cycle_seq import smc_pkg::*; #(
    parameter int AW          = 16,
    parameter int TW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_be,
    output logic          ready,
    output logic          done,
    output logic [15:0]   rdata,
    input  logic [1:0]    cfg_wait_mode,
    input  logic [1:0]    cfg_bus_width,
    input  logic          cfg_lane_mode,
    input  logic          cfg_wr_by_strobe,
    input  logic [TW-1:0] rd_setup,
    input  logic [TW-1:0] rd_pulse,
    input  logic [TW-1:0] rd_hold,
    input  logic [TW-1:0] wr_setup,
    input  logic [TW-1:0] wr_pulse,
    input  logic [TW-1:0] wr_hold,
    input  logic [TW-1:0] cs_setup,
    input  logic [TW-1:0] cs_pulse,
    input  logic [TW-1:0] cs_hold,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_dout,
    output logic          mem_dout_en,
    input  logic [15:0]   mem_din,
    input  logic          mem_wait_n,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_we_n,
    output logic [1:0]    mem_wrb_n,
    output logic [1:0]    mem_bs_n
);
    localparam int LANES = 2;
    localparam int DW    = 8 * LANES;

    phase_t        phase;
    logic          pulse_end, wait_s, start;
    logic          bus16, wait_freeze, wait_ready, wait_on;
    logic [TW-1:0] sel_s, sel_p, sel_h, pulse_eff, hold_eff;
    logic          op_wr;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic [LANES-1:0] op_be;

    // Decode the mode fields; reserved codes fall back to off / 8-bit.
    always_comb begin
        bus16       = (cfg_bus_width == BUS_16);
        wait_freeze = (cfg_wait_mode == WAIT_FREEZE);
        wait_ready  = (cfg_wait_mode == WAIT_READY);
        wait_on     = wait_freeze || wait_ready;
    end

    // Pick the group of counts and apply the minimum pulse and hold rules.
    always_comb begin
        if (!req_wr)               begin sel_s = rd_setup; sel_p = rd_pulse; sel_h = rd_hold; end
        else if (cfg_wr_by_strobe) begin sel_s = wr_setup; sel_p = wr_pulse; sel_h = wr_hold; end
        else                       begin sel_s = cs_setup; sel_p = cs_pulse; sel_h = cs_hold; end
        pulse_eff = (sel_p == '0) ? TW'(1) : sel_p;
        hold_eff  = (wait_on && sel_h == '0) ? TW'(1) : sel_h;
    end

    assign start = req && (phase == PH_IDLE);
    assign ready = (phase == PH_IDLE);
    assign done  = (phase == PH_DONE);

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr    <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            op_be    <= '0;
        end else if (start) begin
            op_wr    <= req_wr;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            op_be    <= req_be;
        end
    end

    // Capture read data on the edge that ends the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata <= '0;
        else if (pulse_end && !op_wr) rdata <= bus16 ? mem_din : {8'h00, mem_din[7:0]};
    end

    assign mem_addr    = op_addr;
    assign mem_dout    = op_wdata;
    assign mem_dout_en = op_wr && (phase == PH_SETUP || phase == PH_PULSE || phase == PH_HOLD);

    smc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(mem_wait_n), .sync_out(wait_s)
    );

    smc_phase_ctl #(.TW(TW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .setup_len(sel_s), .pulse_len(pulse_eff), .hold_len(hold_eff),
        .wait_freeze(wait_freeze), .wait_ready(wait_ready), .wait_low(!wait_s),
        .phase(phase), .pulse_end(pulse_end)
    );

    smc_strobe_map #(.LANES(LANES)) u_map (
        .phase(phase), .op_wr(op_wr), .wr_by_strobe(cfg_wr_by_strobe),
        .bus16(bus16), .lane_mode(cfg_lane_mode), .be(op_be),
        .cs_n(mem_cs_n), .rd_n(mem_rd_n), .we_n(mem_we_n),
        .wrb_n(mem_wrb_n), .bs_n(mem_bs_n)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_rd_n && mem_we_n && mem_wrb_n == 2'b11 && mem_bs_n == 2'b11));
    p_rd_wr_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_we_n && mem_wrb_n == 2'b11));
    p_rdata_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> $stable(rdata));
    p_busy_ignores_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && req) |=> (phase != PH_IDLE && phase != PH_SETUP));
endmodule

// File: tb/tb_smc_cycle_seq.sv
module tb_smc_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        ready, done, mem_dout_en, mem_cs_n, mem_rd_n, mem_we_n;
    logic [15:0] rdata, mem_addr, mem_dout;
    logic [1:0]  cfg_wait_mode = 0, cfg_bus_width = 0;
    logic        cfg_lane_mode = 0, cfg_wr_by_strobe = 1;
    logic [5:0]  rd_setup = 0, rd_pulse = 1, rd_hold = 0;
    logic [5:0]  wr_setup = 0, wr_pulse = 1, wr_hold = 0;
    logic [5:0]  cs_setup = 0, cs_pulse = 1, cs_hold = 0;
    logic [15:0] mem_din = '0;
    logic        mem_wait_n = 1'b1;
    logic [1:0]  mem_wrb_n, mem_bs_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    smc_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .done(done), .rdata(rdata),
        .cfg_wait_mode(cfg_wait_mode), .cfg_bus_width(cfg_bus_width),
        .cfg_lane_mode(cfg_lane_mode), .cfg_wr_by_strobe(cfg_wr_by_strobe),
        .rd_setup(rd_setup), .rd_pulse(rd_pulse), .rd_hold(rd_hold),
        .wr_setup(wr_setup), .wr_pulse(wr_pulse), .wr_hold(wr_hold),
        .cs_setup(cs_setup), .cs_pulse(cs_pulse), .cs_hold(cs_hold),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_wait_n(mem_wait_n), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_wrb_n(mem_wrb_n), .mem_bs_n(mem_bs_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Expected edge (counted from the accepting edge) on which the pulse ends.
    function automatic int exp_pulse_end(input int s, input int p, input int rel, input logic [1:0] mode);
        int e;
        e = s + p;
        if (rel >= 0 && mode == 2'd2 && rel + 2 - s > 0) e = e + (rel + 2 - s);
        if (rel >= 0 && mode == 2'd3 && rel + 3 > e)     e = rel + 3;
        return e;
    endfunction

    // One access. rel>=0: wait low beforehand and released after edge rel.
    // late: wait driven low right after the pulse ends. poke: request while busy.
    task automatic run_access(input bit wr, input int rel, input bit late, input bit poke, input string xtag);
        int s, p, h, pe, he, ende, dd, low_cnt, done_at, done_cnt;
        bit bus16, bw, pat_bad, data_bad;
        logic [15:0] val, adr, wd;
        logic [1:0]  be;
        string tag;
        int bad_act, bad_exp;
        bus16 = (cfg_bus_width == 2'd1);
        bw    = bus16 && cfg_lane_mode;
        if (!wr)                   begin s = rd_setup; p = rd_pulse; h = rd_hold; end
        else if (cfg_wr_by_strobe) begin s = wr_setup; p = wr_pulse; h = wr_hold; end
        else                       begin s = cs_setup; p = cs_pulse; h = cs_hold; end
        pe = (p == 0) ? 1 : p;
        he = (cfg_wait_mode[1] && h == 0) ? 1 : h;
        ende = exp_pulse_end(s, pe, rel, cfg_wait_mode);
        dd = ende + he;
        val = 16'($urandom); adr = 16'($urandom); wd = 16'($urandom);
        be  = 2'($urandom_range(1, 3));
        if (rel >= 0) begin
            mem_wait_n = 1'b0;
            repeat (3) @(negedge clk);
        end
        req = 1'b1; req_wr = wr; req_addr = adr; req_wdata = wd; req_be = be; mem_din = val;
        @(posedge clk); #1; req = 1'b0;
        low_cnt = 0; done_at = -1; done_cnt = 0; pat_bad = 0; data_bad = 0;
        bad_act = 0; bad_exp = 0;
        for (int k = 0; k <= dd + 1; k++) begin
            bit act, pul, win;
            logic ecs, erd, ewe;
            logic [1:0] ewrb, ebs;
            if (k > 0) begin @(posedge clk); #1; end
            act = (k < dd);
            pul = (k >= s) && (k < ende);
            ebs = (act && bus16 && !cfg_lane_mode) ? ~be : 2'b11;
            if (!wr) begin ecs = !act; erd = !pul; win = 0; end
            else if (cfg_wr_by_strobe) begin ecs = !act; erd = 1; win = pul; end
            else begin ecs = !pul; erd = 1; win = act; end
            ewe  = bw ? 1'b1 : !(win && wr);
            ewrb = (bw && win && wr) ? ~be : 2'b11;
            if ({mem_cs_n, mem_rd_n, mem_we_n, mem_wrb_n, mem_bs_n} != {ecs, erd, ewe, ewrb, ebs} && !pat_bad) begin
                pat_bad = 1; bad_act = {mem_cs_n, mem_rd_n, mem_we_n, mem_wrb_n, mem_bs_n};
                bad_exp = {ecs, erd, ewe, ewrb, ebs};
            end
            if (act && (mem_addr != adr || mem_dout_en != wr || (wr && mem_dout != wd))) data_bad = 1;
            if (!wr ? !mem_rd_n : cfg_wr_by_strobe ? (bw ? mem_wrb_n != 2'b11 : !mem_we_n) : !mem_cs_n)
                low_cnt++;
            if (done) begin done_cnt++; if (done_at < 0) done_at = k; end
            if (k == rel) mem_wait_n = 1'b1;
            if (k == ende) begin mem_din = ~val; if (late) mem_wait_n = 1'b0; end
            if (k == 1 && poke) begin req = 1'b1; req_wr = !wr; req_addr = ~adr; end
            if (k == 2) req = 1'b0;
            if (k == dd && !wr) begin
                logic [15:0] er;
                er = bus16 ? val : {8'h00, val[7:0]};
                chk(rdata == er, bus16 ? "R9 read capture" : "R9/R13 8-bit read capture", int'(rdata), int'(er));
            end
        end
        tag = (xtag != "") ? xtag : (cfg_wait_mode == 2'd2 && rel >= 0) ? "R4" :
              (cfg_wait_mode == 2'd3 && rel >= 0) ? "R5" : "R2";
        chk(done_at == dd && done_cnt == 1, {tag, " done edge"}, done_at, dd);
        chk(low_cnt == ende - s, {tag, " strobe low cycles"}, low_cnt, ende - s);
        tag = !bus16 ? "R12 8-bit strobes" : bw ? "R11 per-lane strobes" : "R10 lane-select strobes";
        chk(!pat_bad, tag, bad_act, bad_exp);
        chk(!data_bad, "R2 address/data held", 1, 0);
        mem_wait_n = 1'b1;
        if (poke) begin
            bit quiet;
            quiet = 1;
            for (int k = 0; k < 4; k++) begin
                @(posedge clk); #1;
                if (!ready || !mem_cs_n || done) quiet = 0;
            end
            chk(quiet, "R14 busy request ignored", 0, 1);
        end
        @(negedge clk);
    endtask

    task automatic set_all(input int s, input int p, input int h);
        rd_setup = 6'(s); rd_pulse = 6'(p); rd_hold = 6'(h);
        wr_setup = 6'(s); wr_pulse = 6'(p); wr_hold = 6'(h);
        cs_setup = 6'(s); cs_pulse = 6'(p); cs_hold = 6'(h);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ready && !done && mem_cs_n && mem_rd_n && mem_we_n && mem_wrb_n == 2'b11 && mem_bs_n == 2'b11,
            "R1 reset idle state", {ready, done, mem_cs_n, mem_rd_n, mem_we_n}, 5'b10111);
        @(negedge clk);

        // Basic 8-bit read, then zero pulse and zero setup/hold.
        set_all(2, 3, 1); cfg_bus_width = 0; cfg_wait_mode = 0;
        run_access(0, -1, 0, 0, "R2");
        set_all(0, 0, 0);
        run_access(0, -1, 0, 0, "R2 zero pulse");
        // Wait ignored in mode 0 and reserved mode 1.
        set_all(1, 2, 1); cfg_wait_mode = 0;
        run_access(0, 10, 0, 0, "R3");
        cfg_wait_mode = 1;
        run_access(1, 10, 0, 0, "R13 reserved wait mode");
        // Freeze with forced hold.
        cfg_bus_width = 1; cfg_lane_mode = 0; cfg_wait_mode = 2; set_all(1, 2, 0);
        run_access(0, 6, 0, 0, "R7 forced hold");
        run_access(1, 4, 0, 0, "R8 two-cycle wait latency");
        // Ready mode extension.
        cfg_wait_mode = 3; set_all(2, 2, 1);
        run_access(0, 9, 0, 0, "R5");
        // Wait low only before the pulse, then only in hold.
        cfg_wait_mode = 2; set_all(6, 2, 3);
        run_access(0, 1, 0, 0, "R6 wait in setup");
        run_access(0, -1, 1, 0, "R6 wait in hold");
        cfg_wait_mode = 3;
        run_access(1, -1, 1, 0, "R6 ready wait in hold");
        // Lane schemes and write control modes.
        cfg_wait_mode = 0; set_all(2, 3, 2);
        cfg_lane_mode = 0; cfg_wr_by_strobe = 1;
        run_access(1, -1, 0, 0, "R10");
        cfg_lane_mode = 1;
        run_access(1, -1, 0, 0, "R11");
        run_access(0, -1, 0, 0, "R11 read");
        cfg_wr_by_strobe = 0; cs_setup = 1; cs_pulse = 4; cs_hold = 2;
        run_access(1, -1, 0, 0, "R12 select-timed write");
        cfg_wr_by_strobe = 1; wr_setup = 3; wr_pulse = 1; wr_hold = 0;
        run_access(1, -1, 0, 0, "R12 strobe-timed write");
        // Reserved bus width, busy request, maximum counts.
        cfg_bus_width = 3;
        run_access(0, -1, 0, 0, "R13 reserved width");
        cfg_bus_width = 1;
        run_access(0, -1, 0, 1, "R14");
        set_all(63, 63, 63);
        run_access(0, -1, 0, 0, "R2 max counts");

        // Random accesses across every configuration value.
        for (int i = 0; i < 80; i++) begin
            int rel;
            cfg_wait_mode    = 2'($urandom);
            cfg_bus_width    = 2'($urandom);
            cfg_lane_mode    = 1'($urandom);
            cfg_wr_by_strobe = 1'($urandom);
            rd_setup = 6'($urandom_range(0, 5)); rd_pulse = 6'($urandom_range(0, 5)); rd_hold = 6'($urandom_range(0, 5));
            wr_setup = 6'($urandom_range(0, 5)); wr_pulse = 6'($urandom_range(0, 5)); wr_hold = 6'($urandom_range(0, 5));
            cs_setup = 6'($urandom_range(0, 5)); cs_pulse = 6'($urandom_range(0, 5)); cs_hold = 6'($urandom_range(0, 5));
            rel = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 14)) : -1;
            run_access(1'($urandom), rel, 0, 0, "");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule